// File: doc/BRIEF.md
# Display Data Channel Slave Controller

This block is the target side of a two-wire serial bus used by a display to hand out its identification data. It watches the clock (SCL) and data (SDA) lines through a two-flop synchronizer and finds START and STOP conditions on the synchronized inputs. It compares the first byte after a START with a programmable 7-bit own address, and can also compare it with a fixed segment-pointer address pair. Once it has matched, it shifts data bytes in or out and answers with an acknowledge when software allows it. The lines are driven open-drain: each output only pulls its line low.

A local processor controls the block through a byte-wide register bus with four locations. It services each address match and each finished byte. While an event waits for service, the block holds SCL low and can raise an interrupt. Software reads the received byte, or writes the next byte to send, through the data location. Any access to that location clears the pending events and lets SCL go. A release request lets software abandon a transfer after the byte in flight. Switching the block on takes two writes to the control location.

Register map (bus_addr): 0 control, 1 status, 2 data, 3 own address (bits 6:0). Control bits: 5 enable, 4 segment-address enable, 2 acknowledge enable, 1 release request, 0 interrupt enable. Status bits: 0 address matched, 1 byte finished, 2 slave is transmitting. All other bits read as 0.

Top module: `ddc_slave`

## Requirements
- R1: After reset the control location reads 00h and the status location reads 00h. SCL and SDA are both released and irq is low. Control bits 7, 6 and 3 always read 0.
- R2: While control bit 5 is 0, every control and status bit reads 0 and both scl_oe and sda_oe are 0. Writing control with bit 5 clear during a stretched transfer releases both lines within two clocks.
- R3: A control write while bit 5 is 0 sets only bit 5 (taken from the written data), and bits 4, 2, 1 and 0 stay 0. A second write with bit 5 set loads bits 4, 2, 1 and 0 as written.
- R4: The first byte after a START matches when its upper seven bits equal the own-address register. Its lowest bit gives the direction (1 = slave transmits). A match sets status bit 0. A byte that does not match sets no flag, does not stretch and is not acknowledged.
- R5: With control bit 2 set, the slave pulls SDA low during the ninth clock that follows a matched address byte or a received data byte. With bit 2 clear, SDA is left high. The slave only starts pulling SDA low while SCL is low.
- R6: With control bit 4 set, address bytes 60h and 61h also match. With bit 4 clear, 60h does not match (own address 50h).
- R7: A received or transmitted data byte sets status bit 1 after its eighth clock. SCL is held low for as long as status bit 0 or bit 1 is set.
- R8: A read or write of the data location clears status bits 0 and 1 and releases SCL. A read returns the last received byte. A write provides the byte to transmit.
- R9: irq is high exactly when control bit 0 is set and status bit 0 or bit 1 is set.
- R10: With control bit 1 set, the data byte in flight ends with no flag set, no acknowledge and both lines released, and the slave ignores the bus until the next START. Bit 1 keeps reading 1 until software clears it.
- R11: A STOP returns the slave to idle and clears status bit 0 and the transmit direction. A later START and matching address is served normally.
- R12: In slave transmit the byte goes out MSB first. A master acknowledge loads the next byte from the data location. A master not-acknowledge releases SDA, and the slave stays quiet until a STOP or a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register location select |
| bus_wr | input | 1 | Register write strobe, one clock |
| bus_rd | input | 1 | Register read strobe, one clock (side effect on data location) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected location, combinational |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked on every cycle. SDA is only pulled low while SCL is low. A STOP always leaves the slave idle with no match pending. The address-matched flag only falls after a data access, a STOP or a disable. A master not-acknowledge always frees SDA. The first enabling write never loads more than the enable bit.

Other behaviour can only be shown by driving whole transfers through the bench's open-drain bus. That covers address matching with and without the segment pair, acknowledge on and off, clock stretching until service, the transmitted byte order, early release and shutting the block off in mid-transfer. On every clock the bench's own register model also checks the control readback and the released outputs.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_DATA = 2'd2,
    RA_OWN  = 2'd3
  } reg_addr_e;

  localparam int unsigned CB_PE   = 5;
  localparam int unsigned CB_EDDC = 4;
  localparam int unsigned CB_ACK  = 2;
  localparam int unsigned CB_REL  = 1;
  localparam int unsigned CB_ITE  = 0;

  typedef struct packed {
    logic pe;
    logic eddc;
    logic ack;
    logic rel;
    logic ite;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } phase_e;

endpackage

// File: rtl/ddc_bus_sync.sv
module ddc_bus_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ddc_ctrl_regs.sv
module ddc_ctrl_regs
  import ddc_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter logic [6:0]  OWN_RESET = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              st_adsl,
  input  logic              st_btf,
  input  logic              st_tra,
  input  logic [DW-1:0]     rx_byte,
  output ctrl_t             ctrl,
  output logic [6:0]        own_addr,
  output logic [DW-1:0]     tx_byte,
  output logic              dr_access
);

  ctrl_t         ctrl_q, ctrl_d;
  logic [6:0]    own_q;
  logic [DW-1:0] tx_q;
  logic          ctrl_en, own_en, tx_en;
  reg_addr_e     sel;

  assign sel     = reg_addr_e'(bus_addr);
  assign ctrl_en = bus_wr && (sel == RA_CTRL);
  assign own_en  = bus_wr && (sel == RA_OWN);
  assign tx_en   = bus_wr && (sel == RA_DATA) && ctrl_q.pe;
  assign dr_access = (bus_wr || bus_rd) && (sel == RA_DATA) && ctrl_q.pe;

  // Two-step enable: the first write while disabled only takes the enable bit.
  always_comb begin
    ctrl_d = ctrl_q;
    if (!ctrl_q.pe) begin
      ctrl_d = '{pe: bus_wdata[CB_PE], default: 1'b0};
    end else if (!bus_wdata[CB_PE]) begin
      ctrl_d = '0;
    end else begin
      ctrl_d = '{pe:   1'b1,
                 eddc: bus_wdata[CB_EDDC],
                 ack:  bus_wdata[CB_ACK],
                 rel:  bus_wdata[CB_REL],
                 ite:  bus_wdata[CB_ITE]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= OWN_RESET;
    else if (own_en) own_q <= bus_wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_en) tx_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RA_CTRL: begin
        bus_rdata[CB_PE]   = ctrl_q.pe;
        bus_rdata[CB_EDDC] = ctrl_q.eddc;
        bus_rdata[CB_ACK]  = ctrl_q.ack;
        bus_rdata[CB_REL]  = ctrl_q.rel;
        bus_rdata[CB_ITE]  = ctrl_q.ite;
      end
      RA_STAT: bus_rdata[2:0] = {st_tra, st_btf, st_adsl};
      RA_DATA: bus_rdata = rx_byte;
      RA_OWN:  bus_rdata[6:0] = own_q;
      default: bus_rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign own_addr = own_q;
  assign tx_byte  = tx_q;

  // R3: a write while disabled loads nothing but the enable bit
  a_r3_first_write_pe_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !ctrl_q.pe) |=>
      (ctrl_q.pe == $past(bus_wdata[CB_PE])) && !ctrl_q.eddc && !ctrl_q.ack
      && !ctrl_q.rel && !ctrl_q.ite);

  // R2: writing the enable bit low clears the whole control register
  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !bus_wdata[CB_PE]) |=> (ctrl_q == '0));

endmodule

// File: rtl/ddc_byte_engine.sv
module ddc_byte_engine
  import ddc_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter logic [6:0]  ALT_ADDR = 7'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          pe,
  input  logic          eddc_en,
  input  logic          ack_en,
  input  logic          rel_req,
  input  logic [6:0]    own_addr,
  input  logic [DW-1:0] tx_byte,
  input  logic          dr_access,
  output logic          adsl,
  output logic          btf,
  output logic          tra,
  output logic [DW-1:0] rx_byte,
  output logic          scl_low,
  output logic          sda_low
);

  localparam int unsigned CNTW = $clog2(DW + 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DW);

  phase_e        phase_q, phase_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d, rx_q, rx_d;
  logic          adsl_q, adsl_d, btf_q, btf_d, tra_q, tra_d;
  logic          sda_low_q, sda_low_d, nack_q, nack_d;
  logic          scl_d1, sda_d1;
  logic          scl_rise, scl_fall, start_det, stop_det, addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d1 <= 1'b1;
      sda_d1 <= 1'b1;
    end else begin
      scl_d1 <= scl_s;
      sda_d1 <= sda_s;
    end
  end

  assign scl_rise  = scl_s && !scl_d1;
  assign scl_fall  = !scl_s && scl_d1;
  assign start_det = scl_s && scl_d1 && sda_d1 && !sda_s;
  assign stop_det  = scl_s && scl_d1 && !sda_d1 && sda_s;
  assign addr_hit  = (sh_q[DW-1:1] == own_addr) ||
                     (eddc_en && (sh_q[DW-1:1] == ALT_ADDR));

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    rx_d      = rx_q;
    adsl_d    = adsl_q;
    btf_d     = btf_q;
    tra_d     = tra_q;
    sda_low_d = sda_low_q;
    nack_d    = nack_q;
    if (!pe) begin
      phase_d   = S_IDLE;
      cnt_d     = '0;
      adsl_d    = 1'b0;
      btf_d     = 1'b0;
      tra_d     = 1'b0;
      sda_low_d = 1'b0;
      nack_d    = 1'b0;
    end else begin
      if (dr_access) begin
        adsl_d = 1'b0;
        btf_d  = 1'b0;
      end
      if (start_det) begin
        phase_d   = S_ADDR;
        cnt_d     = '0;
        sda_low_d = 1'b0;
      end else if (stop_det) begin
        phase_d   = S_IDLE;
        adsl_d    = 1'b0;
        tra_d     = 1'b0;
        sda_low_d = 1'b0;
      end else begin
        unique case (phase_q)
          S_ADDR: begin
            if (scl_rise) begin
              sh_d  = {sh_q[DW-2:0], sda_s};
              cnt_d = cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              if (addr_hit) begin
                adsl_d    = 1'b1;
                tra_d     = sh_q[0];
                sda_low_d = ack_en;
                phase_d   = S_ADDR_ACK;
              end else begin
                phase_d = S_IDLE;
              end
            end
          end
          S_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_d = '0;
              if (tra_q) begin
                sh_d      = tx_byte;
                sda_low_d = !tx_byte[DW-1];
                phase_d   = S_TX;
              end else begin
                sda_low_d = 1'b0;
                phase_d   = S_RX;
              end
            end
          end
          S_RX: begin
            if (scl_rise) begin
              sh_d  = {sh_q[DW-2:0], sda_s};
              cnt_d = cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              if (rel_req) begin
                phase_d = S_IDLE;
              end else begin
                rx_d      = sh_q;
                btf_d     = 1'b1;
                sda_low_d = ack_en;
                phase_d   = S_RX_ACK;
              end
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              sda_low_d = 1'b0;
              cnt_d     = '0;
              phase_d   = S_RX;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt_d = cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == CNT_FULL) begin
                sda_low_d = 1'b0;
                if (rel_req) begin
                  phase_d = S_IDLE;
                end else begin
                  btf_d   = 1'b1;
                  phase_d = S_TX_ACK;
                end
              end else begin
                sh_d      = {sh_q[DW-2:0], 1'b0};
                sda_low_d = !sh_q[DW-2];
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise) begin
              nack_d = sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                phase_d = S_IDLE;
              end else begin
                sh_d      = tx_byte;
                sda_low_d = !tx_byte[DW-1];
                cnt_d     = '0;
                phase_d   = S_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= S_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      rx_q      <= '0;
      adsl_q    <= 1'b0;
      btf_q     <= 1'b0;
      tra_q     <= 1'b0;
      sda_low_q <= 1'b0;
      nack_q    <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      rx_q      <= rx_d;
      adsl_q    <= adsl_d;
      btf_q     <= btf_d;
      tra_q     <= tra_d;
      sda_low_q <= sda_low_d;
      nack_q    <= nack_d;
    end
  end

  assign adsl    = adsl_q;
  assign btf     = btf_q;
  assign tra     = tra_q;
  assign rx_byte = rx_q;
  assign scl_low = adsl_q || btf_q;
  assign sda_low = sda_low_q;

  // R5: SDA only starts being pulled low while SCL is low
  a_r5_sda_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_q) |-> !scl_s);

  // R11: a STOP leaves the slave idle with no match pending
  a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pe && stop_det) |=> (phase_q == S_IDLE) && !adsl_q);

  // R8: the match flag only falls after a data access, a STOP or a disable
  a_r8_match_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adsl_q) |-> ($past(dr_access) || $past(stop_det) || !$past(pe)));

  // R12: a master not-acknowledge frees SDA
  a_r12_nack_frees_sda: assert property (@(posedge clk) disable iff (!rst_n)
    (pe && phase_q == S_TX_ACK && scl_fall && nack_q && !start_det && !stop_det)
      |=> !sda_low_q && (phase_q == S_IDLE));

endmodule

// File: rtl/ddc_slave.sv
module ddc_slave
  import ddc_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned SYNC_LEN  = 2,
  parameter logic [6:0]  OWN_RESET = 7'h50,
  parameter logic [6:0]  ALT_ADDR  = 7'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq
);

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  logic [1:0]    line_s;
  ctrl_t         ctrl;
  logic [6:0]    own_addr;
  logic [DW-1:0] tx_byte, rx_byte;
  logic          dr_access, adsl, btf, tra, scl_low, sda_low;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  ddc_bus_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) i_sync (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .async_i ({scl_i, sda_i}),
    .sync_o  (line_s)
  );

  ddc_ctrl_regs #(.DW(DW), .OWN_RESET(OWN_RESET)) i_regs (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .st_adsl   (adsl),
    .st_btf    (btf),
    .st_tra    (tra),
    .rx_byte   (rx_byte),
    .ctrl      (ctrl),
    .own_addr  (own_addr),
    .tx_byte   (tx_byte),
    .dr_access (dr_access)
  );

  ddc_byte_engine #(.DW(DW), .ALT_ADDR(ALT_ADDR)) i_engine (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .pe        (ctrl.pe),
    .eddc_en   (ctrl.eddc),
    .ack_en    (ctrl.ack),
    .rel_req   (ctrl.rel),
    .own_addr  (own_addr),
    .tx_byte   (tx_byte),
    .dr_access (dr_access),
    .adsl      (adsl),
    .btf       (btf),
    .tra       (tra),
    .rx_byte   (rx_byte),
    .scl_low   (scl_low),
    .sda_low   (sda_low)
  );

  assign scl_oe = ctrl.pe && scl_low;
  assign sda_oe = ctrl.pe && sda_low;
  assign irq    = ctrl.ite && (adsl || btf);

endmodule

// File: tb/test_ddc_slave.sv
module test_ddc_slave;

  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       m_scl_low, m_sda_low;
  logic       scl_line, sda_line;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit model_on = 0;
  logic [7:0] ctrl_m;

  always #4 clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  ddc_slave i_ddc_slave (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural model of the control register, compared every clock
  always @(posedge clk) begin
    if (!rst_n) ctrl_m <= 8'h00;
    else if (bus_wr && bus_addr == 2'd0) begin
      if (!ctrl_m[5])          ctrl_m <= {2'b00, bus_wdata[5], 5'b0};
      else if (!bus_wdata[5])  ctrl_m <= 8'h00;
      else                     ctrl_m <= bus_wdata & 8'h37;
    end
  end

  always @(posedge clk) begin
    #2;
    if (model_on) begin
      if (bus_addr == 2'd0) chk("R1 control readback", bus_rdata, ctrl_m);
      if (!ctrl_m[5]) chk("R2 lines released while disabled", {scl_oe, sda_oe, irq}, 0);
      else if (!ctrl_m[0]) chk("R9 irq gated by enable", irq, 0);
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_addr = 2'd0;
  endtask

  task automatic m_start();
    m_sda_low = 1'b1; wait_clks(HALF);
    m_scl_low = 1'b1; wait_clks(HALF);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wait_clks(HALF);
    m_scl_low = 1'b0; wait_clks(HALF);
    m_sda_low = 1'b0; wait_clks(HALF);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda_low = !b; wait_clks(HALF);
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
    wait_clks(HALF / 2);
    r = sda_line;
    wait_clks(HALF / 2);
    m_scl_low = 1'b1; wait_clks(HALF);
    m_sda_low = 1'b0;
  endtask

  task automatic m_send(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(v[i], r);
  endtask

  task automatic m_recv(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      v[i] = r;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic r;
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(5);
    model_on = 1;

    // R1 reset state
    peek(2'd0, d); chk("R1 control after reset", d, 8'h00);
    peek(2'd1, d); chk("R1 status after reset", d, 8'h00);
    chk("R1 outputs after reset", {scl_oe, sda_oe, irq}, 0);

    // R3 two-step enable, R1 reserved bits
    reg_wr(2'd0, 8'hFF); peek(2'd0, d); chk("R3 first write sets only enable", d, 8'h20);
    reg_wr(2'd0, 8'hFF); peek(2'd0, d); chk("R3 second write loads bits, R1 reserved zero", d, 8'h37);
    reg_wr(2'd0, 8'h00); peek(2'd0, d); chk("R2 disable clears control", d, 8'h00);

    reg_wr(2'd3, 8'h50); peek(2'd3, d); chk("R4 own address readback", d, 8'h50);
    reg_wr(2'd0, 8'h25); reg_wr(2'd0, 8'h25);

    // Write transfer: R4 R5 R7 R8 R9
    m_start(); m_send(8'hA0); wait_clks(6);
    peek(2'd1, d); chk("R4 address match flag", d, 8'h01);
    chk("R5 ack driven, R7 stretch, R9 irq", {scl_oe, sda_oe, irq}, 3'b111);
    wait_clks(30); chk("R7 SCL held low", scl_line, 0);
    reg_rd(2'd2, d); wait_clks(3);
    chk("R8 access releases SCL and irq", {scl_oe, irq}, 0);
    m_bit(1'b1, r); chk("R5 address acknowledged", r, 0);
    m_send(8'h3C); wait_clks(6);
    peek(2'd1, d); chk("R7 byte finished flag", d, 8'h02);
    chk("R9 irq on byte finished", irq, 1);
    reg_rd(2'd2, d); chk("R8 received byte", d, 8'h3C);
    m_bit(1'b1, r); chk("R5 data acknowledged", r, 0);
    m_stop(); wait_clks(4);
    peek(2'd1, d); chk("R11 status idle after STOP", d, 8'h00);

    // Ack and interrupt disabled: R5 R9
    reg_wr(2'd0, 8'h20);
    m_start(); m_send(8'hA0); wait_clks(6);
    peek(2'd1, d); chk("R4 match with ack off", d, 8'h01);
    chk("R9 irq low with enable clear, R5 no ack", {irq, sda_oe}, 0);
    reg_rd(2'd2, d);
    m_bit(1'b1, r); chk("R5 no acknowledge", r, 1);
    m_stop();

    // Wrong address: R4
    reg_wr(2'd0, 8'h25);
    m_start(); m_send(8'h22); wait_clks(6);
    peek(2'd1, d); chk("R4 foreign address no flag", d, 8'h00);
    chk("R4 foreign address no stretch", scl_oe, 0);
    m_bit(1'b1, r); chk("R4 foreign address not acknowledged", r, 1);
    m_stop();

    // Segment address: R6
    m_start(); m_send(8'h60); wait_clks(6);
    peek(2'd1, d); chk("R6 60h ignored when disabled", d, 8'h00);
    m_bit(1'b1, r); chk("R6 60h not acknowledged", r, 1);
    m_stop();
    reg_wr(2'd0, 8'h35);
    m_start(); m_send(8'h60); wait_clks(6);
    peek(2'd1, d); chk("R6 60h matched when enabled", d, 8'h01);
    reg_rd(2'd2, d);
    m_bit(1'b1, r); chk("R6 60h acknowledged", r, 0);
    m_stop();

    // Slave transmit: R12
    reg_wr(2'd0, 8'h25);
    m_start(); m_send(8'hA1); wait_clks(6);
    peek(2'd1, d); chk("R12 read direction flagged", d, 8'h05);
    reg_wr(2'd2, 8'h96);
    m_bit(1'b1, r); chk("R12 read address acknowledged", r, 0);
    m_recv(d); chk("R12 first byte MSB first", d, 8'h96);
    wait_clks(6);
    peek(2'd1, d); chk("R7 byte finished in transmit", d, 8'h06);
    reg_wr(2'd2, 8'h5A);
    m_bit(1'b0, r);
    m_recv(d); chk("R12 next byte after master ack", d, 8'h5A);
    reg_rd(2'd2, d);
    m_bit(1'b1, r);
    wait_clks(6); chk("R12 SDA freed after nack", sda_oe, 0);
    m_bit(1'b1, r); chk("R12 quiet after nack", r, 1);
    m_stop();

    // Release request: R10
    reg_wr(2'd0, 8'h27);
    m_start(); m_send(8'hA0); wait_clks(6);
    reg_rd(2'd2, d);
    m_bit(1'b1, r); chk("R10 address still served", r, 0);
    m_send(8'h77); wait_clks(6);
    peek(2'd1, d); chk("R10 no flag on released byte", d, 8'h00);
    chk("R10 lines released", {scl_oe, sda_oe, irq}, 0);
    m_bit(1'b1, r); chk("R10 no acknowledge", r, 1);
    peek(2'd0, d); chk("R10 request bit stays set", d, 8'h27);
    m_send(8'h11); wait_clks(6);
    peek(2'd1, d); chk("R10 ignores bus until START", d, 8'h00);
    m_stop();

    // Disable mid transfer: R2
    reg_wr(2'd0, 8'h25);
    m_start(); m_send(8'hA0); wait_clks(6);
    chk("R2 stretching before disable", scl_oe, 1);
    reg_wr(2'd0, 8'h00); wait_clks(2);
    chk("R2 lines released after disable", {scl_oe, sda_oe}, 0);
    peek(2'd1, d); chk("R2 status cleared on disable", d, 8'h00);
    m_stop();

    // STOP then new transfer: R11
    reg_wr(2'd0, 8'h20); reg_wr(2'd0, 8'h25);
    m_start(); m_send(8'hA0); wait_clks(6);
    reg_rd(2'd2, d);
    m_bit(1'b1, r);
    m_stop(); wait_clks(4);
    peek(2'd1, d); chk("R11 idle after STOP", d, 8'h00);
    m_start(); m_send(8'hA0); wait_clks(6);
    peek(2'd1, d); chk("R11 new START served", d, 8'h01);
    reg_rd(2'd2, d);
    m_bit(1'b1, r);
    m_stop();

    wait_clks(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule